// File: doc/BRIEF.md
# Memory Port Single-Beat Request Sequencer

This block sits between a simple command source and the native request port of a multi-port memory controller with a 64-bit data path. A command carries an address, a direction flag, write data, byte enables and a size flag. For a write, the block first loads the data beat into the controller's write data FIFO with a one-cycle push. Only on the next cycle does it raise the address request. It holds that request until the controller acknowledges it. A read raises the address request with the direction flag set and waits for the controller's read-data strobe.

Word (32-bit) transfers use the same full-width beat. For a word write, the block copies the low 32 bits of the command data into both lanes and enables only the lane that the address selects. For a word read, it returns that lane right-aligned. A timeout limits how long the block waits for an acknowledge. The block accepts a new command only when it is idle, so no push from an earlier transfer can still be pending when the next request is raised.

Top module: `mem_req_seq`

## Requirements
- R1: After reset, ready_o is 1 and mc_addr_req_o, mc_wr_push_o, done_o and err_o are 0.
- R2: A command is taken only in a cycle where ready_o is 1. A cmd_valid_i seen while the block is busy is ignored: it does not change the address of the transfer in flight, and it causes no further push or request.
- R3: For a write, mc_wr_push_o is high for exactly one cycle and carries the beat on mc_wr_data_o/mc_wr_be_o. mc_addr_req_o rises in the next cycle, never earlier and never in the same cycle as a push.
- R4: While mc_wr_full_i is 1, mc_wr_push_o stays 0 and no request is raised. The push happens in the first cycle in which full is 0.
- R5: mc_addr_req_o stays high until mc_addr_ack_i is sampled high, then drops in the next cycle. mc_addr_o and mc_rnw_o stay stable while the request is pending.
- R6: For a write, done_o pulses for one cycle in the cycle after the acknowledge, and ready_o returns in the following cycle.
- R7: A read raises the request with mc_rnw_o=1 and pushes no data. The block captures mc_rd_data_i on the cycle mc_rd_valid_i is high, and done_o pulses in the next cycle with the data on rdata_o.
- R8: For a word write (cmd_word_i=1), mc_wr_data_o holds the low 32 command bits in both halves. mc_wr_be_o is 0xF0 when address bit 2 is 1 and 0x0F when it is 0, and cmd_be_i is ignored. For a double-word write, mc_wr_be_o equals cmd_be_i.
- R9: For a word read, rdata_o[31:0] is the read-data half selected by address bit 2 (bit 2 = 1 selects the upper half), and rdata_o[63:32] is 0.
- R10: If no acknowledge arrives within TIMEOUT_CYC request cycles, the request drops, err_o pulses for one cycle with no done_o, and the block returns to idle.
- R11: An acknowledge that arrives in the last allowed request cycle completes the transfer normally, with done_o and without err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe, taken when ready_o is 1 |
| cmd_rnw_i | input | 1 | 1 = read, 0 = write |
| cmd_word_i | input | 1 | 1 = 32-bit transfer, 0 = 64-bit transfer |
| cmd_addr_i | input | ADDR_W | Byte address |
| cmd_wdata_i | input | DATA_W | Write data |
| cmd_be_i | input | DATA_W/8 | Byte enables for double-word writes |
| ready_o | output | 1 | Idle, ready to take a command |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle acknowledge timeout pulse |
| rdata_o | output | DATA_W | Captured read data |
| mc_addr_req_o | output | 1 | Address request to the controller |
| mc_rnw_o | output | 1 | Direction flag for the request |
| mc_addr_o | output | ADDR_W | Request address |
| mc_addr_ack_i | input | 1 | Address acknowledge from the controller |
| mc_wr_push_o | output | 1 | Write FIFO push pulse |
| mc_wr_data_o | output | DATA_W | Write FIFO data |
| mc_wr_be_o | output | DATA_W/8 | Write FIFO byte enables |
| mc_wr_full_i | input | 1 | Write FIFO full flag |
| mc_rd_valid_i | input | 1 | Read data valid strobe |
| mc_rd_data_i | input | DATA_W | Read data |

## Verification
The bench builds the block with DATA_W=64, ADDR_W=16 and TIMEOUT_CYC=12. The short timeout makes the error path reachable in a few cycles. It also allows both boundary cases to be checked: an acknowledge in the twelfth request cycle, which must still complete, and no acknowledge at all, which must give exactly twelve request cycles and then the error pulse. Keeping the data width at 64 exercises both word lanes through address bit 2, for reads and for writes.

// File: rtl/mem_req_pkg.sv
package mem_req_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PUSH   = 3'd1,
    ST_REQ    = 3'd2,
    ST_RDWAIT = 3'd3,
    ST_DONE   = 3'd4,
    ST_ERR    = 3'd5
  } seq_state_e;
endpackage

// File: rtl/mem_req_cmd_reg.sv
module mem_req_cmd_reg #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              cmd_rnw_i,
  input  logic              cmd_word_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  input  logic [BE_W-1:0]   cmd_be_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rnw_o,
  output logic              word_o,
  output logic              lane_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [BE_W-1:0]   be_o
);
  localparam int HALF_W   = DATA_W / 2;
  localparam int HALF_BE  = BE_W / 2;
  localparam int LANE_BIT = $clog2(BE_W) - 1;

  logic              lane_sel;
  logic [DATA_W-1:0] wdata_fmt;
  logic [BE_W-1:0]   be_fmt;

  assign lane_sel = cmd_addr_i[LANE_BIT];

  // Word beats: replicate low half, enable only the addressed lane.
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign wdata_fmt[h*HALF_W +: HALF_W] = cmd_word_i ? cmd_wdata_i[HALF_W-1:0]
                                                      : cmd_wdata_i[h*HALF_W +: HALF_W];
  end

  for (genvar b = 0; b < BE_W; b++) begin : g_be
    localparam bit UPPER = (b >= HALF_BE);
    assign be_fmt[b] = cmd_word_i ? (lane_sel == UPPER) : cmd_be_i[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      rnw_o   <= 1'b0;
      word_o  <= 1'b0;
      lane_o  <= 1'b0;
      wdata_o <= '0;
      be_o    <= '0;
    end else if (load_i) begin
      addr_o  <= cmd_addr_i;
      rnw_o   <= cmd_rnw_i;
      word_o  <= cmd_word_i;
      lane_o  <= lane_sel;
      wdata_o <= wdata_fmt;
      be_o    <= be_fmt;
    end
  end
endmodule

// File: rtl/mem_req_rd_capture.sv
module mem_req_rd_capture #(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              word_i,
  input  logic              lane_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] lane_data;
  logic [DATA_W-1:0] rdata_fmt;

  assign lane_data = lane_i ? rd_data_i[DATA_W-1:HALF_W] : rd_data_i[HALF_W-1:0];
  assign rdata_fmt = word_i ? {{HALF_W{1'b0}}, lane_data} : rd_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (capture_i) rdata_o <= rdata_fmt;
  end
endmodule

// File: rtl/mem_req_timer.sv
module mem_req_timer #(
  parameter int TIMEOUT_CYC = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (!expire_o) cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/mem_req_fsm.sv
module mem_req_fsm
  import mem_req_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  logic cmd_rnw_i,
  input  logic rnw_q_i,
  input  logic ack_i,
  input  logic full_i,
  input  logic rd_valid_i,
  input  logic expire_i,
  output logic ready_o,
  output logic load_o,
  output logic push_o,
  output logic req_o,
  output logic capture_o,
  output logic timer_run_o,
  output logic done_o,
  output logic err_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    ready_o     = 1'b0;
    load_o      = 1'b0;
    push_o      = 1'b0;
    req_o       = 1'b0;
    capture_o   = 1'b0;
    timer_run_o = 1'b0;
    done_o      = 1'b0;
    err_o       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        ready_o = 1'b1;
        if (cmd_valid_i) begin
          load_o  = 1'b1;
          state_d = cmd_rnw_i ? ST_REQ : ST_PUSH;
        end
      end
      ST_PUSH: begin
        // Push only when the FIFO can take it; request follows next cycle.
        push_o = !full_i;
        if (!full_i) state_d = ST_REQ;
      end
      ST_REQ: begin
        req_o       = 1'b1;
        timer_run_o = 1'b1;
        if (ack_i)         state_d = rnw_q_i ? ST_RDWAIT : ST_DONE;
        else if (expire_i) state_d = ST_ERR;
      end
      ST_RDWAIT: begin
        if (rd_valid_i) begin
          capture_o = 1'b1;
          state_d   = ST_DONE;
        end
      end
      ST_DONE: begin
        done_o  = 1'b1;
        state_d = ST_IDLE;
      end
      ST_ERR: begin
        err_o   = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/mem_req_seq.sv
module mem_req_seq #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 64,
  parameter int TIMEOUT_CYC = 256,
  localparam int BE_W       = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_rnw_i,
  input  logic              cmd_word_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  input  logic [BE_W-1:0]   cmd_be_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mc_addr_req_o,
  output logic              mc_rnw_o,
  output logic [ADDR_W-1:0] mc_addr_o,
  input  logic              mc_addr_ack_i,
  output logic              mc_wr_push_o,
  output logic [DATA_W-1:0] mc_wr_data_o,
  output logic [BE_W-1:0]   mc_wr_be_o,
  input  logic              mc_wr_full_i,
  input  logic              mc_rd_valid_i,
  input  logic [DATA_W-1:0] mc_rd_data_i
);
  logic load, capture, timer_run, expire, word_q, lane_q;

  mem_req_cmd_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .cmd_rnw_i   (cmd_rnw_i),
    .cmd_word_i  (cmd_word_i),
    .cmd_addr_i  (cmd_addr_i),
    .cmd_wdata_i (cmd_wdata_i),
    .cmd_be_i    (cmd_be_i),
    .addr_o      (mc_addr_o),
    .rnw_o       (mc_rnw_o),
    .word_o      (word_q),
    .lane_o      (lane_q),
    .wdata_o     (mc_wr_data_o),
    .be_o        (mc_wr_be_o)
  );

  mem_req_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_rnw_i   (cmd_rnw_i),
    .rnw_q_i     (mc_rnw_o),
    .ack_i       (mc_addr_ack_i),
    .full_i      (mc_wr_full_i),
    .rd_valid_i  (mc_rd_valid_i),
    .expire_i    (expire),
    .ready_o     (ready_o),
    .load_o      (load),
    .push_o      (mc_wr_push_o),
    .req_o       (mc_addr_req_o),
    .capture_o   (capture),
    .timer_run_o (timer_run),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  mem_req_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (timer_run),
    .expire_o (expire)
  );

  mem_req_rd_capture #(.DATA_W(DATA_W)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .word_i    (word_q),
    .lane_i    (lane_q),
    .rd_data_i (mc_rd_data_i),
    .rdata_o   (rdata_o)
  );
endmodule

// File: rtl/mem_req_seq_chk.sv
module mem_req_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              done_o,
  input logic              err_o,
  input logic              mc_addr_req_o,
  input logic              mc_rnw_o,
  input logic [ADDR_W-1:0] mc_addr_o,
  input logic              mc_addr_ack_i,
  input logic              mc_wr_push_o,
  input logic              mc_wr_full_i
);
  p_req_after_push_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_wr_push_o |=> mc_addr_req_o);

  p_push_not_with_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mc_wr_push_o && mc_addr_req_o));

  p_no_push_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_wr_full_i |-> !mc_wr_push_o);

  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mc_addr_req_o && !mc_addr_ack_i) |=> (mc_addr_req_o || err_o));

  p_req_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mc_addr_req_o && mc_addr_ack_i) |=> !mc_addr_req_o);

  p_addr_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mc_addr_req_o && !mc_addr_ack_i) |=> ($stable(mc_addr_o) && $stable(mc_rnw_o)));

  p_write_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mc_addr_req_o && mc_addr_ack_i && !mc_rnw_o) |=> done_o);

  p_read_no_push_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mc_addr_req_o && mc_rnw_o) |=> !mc_wr_push_o);

  p_done_err_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_o, ready_o}));

  p_err_after_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($past(mc_addr_req_o) && !$past(mc_addr_ack_i)));
endmodule

bind mem_req_seq mem_req_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ready_o       (ready_o),
  .done_o        (done_o),
  .err_o         (err_o),
  .mc_addr_req_o (mc_addr_req_o),
  .mc_rnw_o      (mc_rnw_o),
  .mc_addr_o     (mc_addr_o),
  .mc_addr_ack_i (mc_addr_ack_i),
  .mc_wr_push_o  (mc_wr_push_o),
  .mc_wr_full_i  (mc_wr_full_i)
);

// File: tb/mem_req_seq_tb.sv
module mem_req_seq_tb;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 64;
  localparam int BE_W   = DATA_W / 8;
  localparam int TMO    = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_valid = 1'b0, cmd_rnw = 1'b0, cmd_word = 1'b0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [DATA_W-1:0] cmd_wdata = '0;
  logic [BE_W-1:0]   cmd_be = '0;
  logic ready, done, err;
  logic [DATA_W-1:0] rdata;
  logic req, rnw, push;
  logic [ADDR_W-1:0] addr;
  logic ack = 1'b0, full = 1'b0, rd_valid = 1'b0;
  logic [DATA_W-1:0] wr_data, rd_data = '0;
  logic [BE_W-1:0] wr_be;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  mem_req_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT_CYC(TMO)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid), .cmd_rnw_i(cmd_rnw), .cmd_word_i(cmd_word),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata), .cmd_be_i(cmd_be),
    .ready_o(ready), .done_o(done), .err_o(err), .rdata_o(rdata),
    .mc_addr_req_o(req), .mc_rnw_o(rnw), .mc_addr_o(addr), .mc_addr_ack_i(ack),
    .mc_wr_push_o(push), .mc_wr_data_o(wr_data), .mc_wr_be_o(wr_be),
    .mc_wr_full_i(full), .mc_rd_valid_i(rd_valid), .mc_rd_data_i(rd_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic r, input logic w, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, input logic [BE_W-1:0] b);
    @(negedge clk);
    chk("R2 ready before cmd", ready, 1);
    cmd_valid = 1'b1; cmd_rnw = r; cmd_word = w; cmd_addr = a; cmd_wdata = d; cmd_be = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Write with ack after ack_delay extra request cycles.
  task automatic t_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input logic [BE_W-1:0] b, input logic w, input int ack_delay);
    logic [DATA_W-1:0] exp_d;
    logic [BE_W-1:0] exp_b;
    exp_d = w ? {d[31:0], d[31:0]} : d;
    exp_b = w ? (a[2] ? 8'hF0 : 8'h0F) : b;
    issue(1'b0, w, a, d, b);
    chk("R3 push pulse", push, 1);
    chk("R3 no req with push", req, 0);
    chk(w ? "R8 word data" : "R3 push data", wr_data, exp_d);
    chk(w ? "R8 word be" : "R8 dword be", wr_be, exp_b);
    @(negedge clk);
    chk("R3 req after push", req, 1);
    chk("R3 single push", push, 0);
    chk("R5 rnw write", rnw, 0);
    chk("R5 addr", addr, a);
    for (int i = 0; i < ack_delay; i++) begin
      @(negedge clk);
      chk("R5 req held", req, 1);
      chk("R5 addr stable", addr, a);
      chk("R11 no err before limit", err, 0);
    end
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R5 req drop", req, 0);
    chk("R6 done pulse", done, 1);
    chk("R11 no err", err, 0);
    @(negedge clk);
    chk("R6 done one cycle", done, 0);
    chk("R6 ready back", ready, 1);
  endtask

  task automatic t_read(input logic [ADDR_W-1:0] a, input logic w,
                        input logic [DATA_W-1:0] mem, input int wait_cyc);
    logic [DATA_W-1:0] exp_r;
    exp_r = w ? {32'h0, (a[2] ? mem[63:32] : mem[31:0])} : mem;
    issue(1'b1, w, a, 64'hDEAD_BEEF_0000_1111, 8'hFF);
    chk("R7 req read", req, 1);
    chk("R7 rnw read", rnw, 1);
    chk("R7 no push", push, 0);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R7 req drop", req, 0);
    chk("R7 no early done", done, 0);
    for (int i = 0; i < wait_cyc; i++) begin
      @(negedge clk);
      chk("R7 waiting", done, 0);
      chk("R7 no push wait", push, 0);
    end
    rd_valid = 1'b1; rd_data = mem;
    @(negedge clk);
    rd_valid = 1'b0; rd_data = '0;
    chk("R7 read done", done, 1);
    chk(w ? "R9 word rdata" : "R7 rdata", rdata, exp_r);
    @(negedge clk);
    chk("R7 ready back", ready, 1);
    chk("R7 rdata held", rdata, exp_r);
  endtask

  task automatic t_full();
    full = 1'b1;
    issue(1'b0, 1'b0, 16'h0040, 64'h0123_4567_89AB_CDEF, 8'hFF);
    chk("R4 no push full", push, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R4 stall push", push, 0);
      chk("R4 stall req", req, 0);
    end
    full = 1'b0;
    #1;
    chk("R4 push on clear", push, 1);
    @(negedge clk);
    chk("R4 req after stall", req, 1);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R4 done", done, 1);
    @(negedge clk);
  endtask

  task automatic t_busy();
    issue(1'b0, 1'b0, 16'h0100, 64'h1111_2222_3333_4444, 8'hFF);
    cmd_valid = 1'b1; cmd_addr = 16'h0200; cmd_rnw = 1'b1;
    @(negedge clk);
    chk("R2 addr kept", addr, 16'h0100);
    chk("R2 rnw kept", rnw, 0);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0; cmd_valid = 1'b0;
    chk("R2 done", done, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 no extra req", req, 0);
      chk("R2 no extra push", push, 0);
      chk("R2 idle", ready, 1);
    end
  endtask

  task automatic t_timeout();
    int n_req;
    n_req = 0;
    issue(1'b0, 1'b0, 16'h0300, 64'hAAAA_5555_AAAA_5555, 8'h3C);
    @(negedge clk);
    while (req && n_req < 50) begin
      n_req++;
      @(negedge clk);
    end
    chk("R10 req cycles", 64'(n_req), 64'(TMO));
    chk("R10 err pulse", err, 1);
    chk("R10 no done", done, 0);
    chk("R10 req low", req, 0);
    @(negedge clk);
    chk("R10 err one cycle", err, 0);
    chk("R10 idle", ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready reset", ready, 1);
    chk("R1 req reset", req, 0);
    chk("R1 push reset", push, 0);
    chk("R1 done/err reset", {done, err}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {ready, req, push}, 3'b100);
    t_write(16'h0008, 64'hCAFE_F00D_1234_5678, 8'hA5, 1'b0, 0);
    t_write(16'h0010, 64'h0BAD_0BAD_0BAD_0BAD, 8'hFF, 1'b0, 4);
    t_write(16'h0014, 64'hFFFF_FFFF_7654_3210, 8'h00, 1'b1, 1);
    t_write(16'h0018, 64'h0000_0000_89AB_CDEF, 8'hFF, 1'b1, 0);
    t_write(16'h0020, 64'h5A5A_5A5A_A5A5_A5A5, 8'h0F, 1'b0, TMO - 1);
    t_read(16'h0028, 1'b0, 64'h0102_0304_0506_0708, 0);
    t_read(16'h002C, 1'b1, 64'h8877_6655_4433_2211, 2);
    t_read(16'h0030, 1'b1, 64'h8877_6655_4433_2211, 1);
    t_full();
    t_busy();
    t_timeout();
    t_write(16'h0038, 64'h1357_9BDF_2468_ACE0, 8'hC3, 1'b0, 2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule